// File: doc/BRIEF.md
# Data Register File with Pointer-Based Indirect Access

This block holds the byte-wide data register space of a small microcontroller core. A 5-bit file address, taken from the instruction, selects one location. The low eight addresses hold special-function registers. General-purpose storage starts at address 8. When the instruction names address 0, the access goes instead to the location whose address is held in the low five bits of the pointer register at address 4. This is how the core reaches a register that is chosen at run time.

The block also holds the status byte at address 3. Its bit 0 (carry) and bit 2 (zero) are also loaded from ALU flag strobes, and both flags are presented as outputs. The read path is purely combinational from the address and the current register contents. A write, coming from the ALU result, takes effect on the next rising clock edge. Addresses that this block does not implement read as zero and ignore writes. The port latches and the program-counter byte are served by neighbouring blocks.

Top module: `data_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every address 0 to 31 reads 0x00, and both carry and zero outputs are 0.
- R2: General-purpose locations 8 to 8+GPR_COUNT-1 store `wr_data` on a clock edge with `wr_en` high and return it afterwards.
- R3: Addresses 2, 5, 6, 7 and every address at or above 8+GPR_COUNT read 0x00, and writes to them change no readable location.
- R4: Address 1 is a plain byte register: it keeps its value across cycles with no write and never counts.
- R5: Address 4 is the pointer register and stores all 8 bits written to it.
- R6: An access at address 0 reads or writes the location whose address equals bits 4:0 of the pointer; bits 7:5 of the pointer are ignored.
- R7: With pointer bits 4:0 equal to 0, an access at address 0 reads 0x00 and a write there changes nothing.
- R8: Address 3 stores all 8 bits written to it; output `carry` always equals its bit 0 and `zero` its bit 2.
- R9: With `carry_we` high, bit 0 of address 3 takes `carry_in` at the clock edge; with `zero_we` high, bit 2 takes `zero_in`.
- R10: When a write to address 3 and a flag strobe occur in the same cycle, the strobed bits take the flag inputs and the other bits take `wr_data`.
- R11: `rd_data` reflects the selected location in the same cycle that `addr` is applied, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | File address from the instruction |
| wr_en | input | 1 | Write `wr_data` to the selected location |
| wr_data | input | 8 | Write data from the ALU result |
| carry_we | input | 1 | Load the carry flag |
| carry_in | input | 1 | New carry value |
| zero_we | input | 1 | Load the zero flag |
| zero_in | input | 1 | New zero value |
| rd_data | output | 8 | Read data of the selected location |
| carry | output | 1 | Current carry flag (status bit 0) |
| zero | output | 1 | Current zero flag (status bit 2) |

## Verification
A wrong pointer value shows up at the next read through address 0. That read returns data from the wrong location, and an indirect write lands in the wrong cell; the damage appears later, when that cell is read directly. A corrupted status byte is visible at once on `carry` and `zero`, in the cycle after the bad edge. A write that leaks into an unimplemented address has no visible effect there, because such addresses always read zero. It is caught only when it corrupts an aliased implemented location. For that reason, every read of every address is compared with a full byte-level model.

// File: rtl/data_regfile.sv
module data_regfile #(
  parameter int GPR_COUNT = 16,
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          carry_we,
  input  logic          carry_in,
  input  logic          zero_we,
  input  logic          zero_in,
  output logic [DW-1:0] rd_data,
  output logic          carry,
  output logic          zero
);
  localparam int SPACE    = 1 << AW;
  localparam int GPR_BASE = 8;
  localparam int GPR_MAX  = SPACE - GPR_BASE;
  localparam int GPR_N    = (GPR_COUNT > GPR_MAX) ? GPR_MAX : ((GPR_COUNT < 1) ? 1 : GPR_COUNT);
  localparam logic [AW-1:0] A_IND  = AW'(0);
  localparam logic [AW-1:0] A_TMR  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_PTR  = AW'(4);
  localparam int C_BIT = 0;
  localparam int Z_BIT = 2;

  logic [DW-1:0] tmr_q, stat_q, fsr_q, stat_d, gpr_rd;
  logic [DW-1:0] gpr_q [GPR_N];
  logic [AW-1:0] ea;
  logic          gpr_hit;

  assign ea = (addr == A_IND) ? fsr_q[AW-1:0] : addr;

  always_comb begin
    stat_d = (wr_en && ea == A_STAT) ? wr_data : stat_q;
    if (carry_we) stat_d[C_BIT] = carry_in;
    if (zero_we)  stat_d[Z_BIT] = zero_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      stat_q <= '0;
      fsr_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en && ea == A_TMR) tmr_q <= wr_data;
      if (wr_en && ea == A_PTR) fsr_q <= wr_data;
    end
  end

  for (genvar g = 0; g < GPR_N; g++) begin : g_gpr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gpr_q[g] <= '0;
      else if (wr_en && ea == AW'(GPR_BASE + g)) gpr_q[g] <= wr_data;
    end
  end

  always_comb begin
    gpr_hit = 1'b0;
    gpr_rd  = '0;
    for (int g = 0; g < GPR_N; g++) begin
      if (ea == AW'(GPR_BASE + g)) begin
        gpr_hit = 1'b1;
        gpr_rd  = gpr_q[g];
      end
    end
  end

  always_comb begin
    case (ea)
      A_TMR:   rd_data = tmr_q;
      A_STAT:  rd_data = stat_q;
      A_PTR:   rd_data = fsr_q;
      default: rd_data = gpr_hit ? gpr_rd : '0;
    endcase
  end

  assign carry = stat_q[C_BIT];
  assign zero  = stat_q[Z_BIT];
endmodule

// File: rtl/data_regfile_chk.sv
module data_regfile_chk #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int GPR_N = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          carry_we,
  input logic          carry_in,
  input logic          zero_we,
  input logic          zero_in,
  input logic [DW-1:0] rd_data,
  input logic          carry,
  input logic          zero,
  input logic [DW-1:0] fsr
);
  logic [AW-1:0] tgt;
  logic          tgt_impl;
  assign tgt = (addr == '0) ? fsr[AW-1:0] : addr;
  assign tgt_impl = (tgt == AW'(1)) || (tgt == AW'(3)) || (tgt == AW'(4)) ||
                    (int'(tgt) >= 8 && int'(tgt) < 8 + GPR_N);

  AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_impl |-> rd_data == '0); // R3
  AST_SELF_POINTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0 && fsr[AW-1:0] == '0) |-> rd_data == '0); // R7
  AST_POINTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt == AW'(4)) |=> fsr == $past(wr_data)); // R5
  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    carry_we |=> carry == $past(carry_in)); // R9
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    zero_we |=> zero == $past(zero_in)); // R9
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_we && !(wr_en && tgt == AW'(3))) |=> $stable(carry)); // R8
endmodule

bind data_regfile data_regfile_chk #(.AW(AW), .DW(DW), .GPR_N(GPR_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .carry_we(carry_we), .carry_in(carry_in), .zero_we(zero_we), .zero_in(zero_in),
  .rd_data(rd_data), .carry(carry), .zero(zero), .fsr(fsr_q)
);

// File: tb/test_data_regfile.sv
module test_data_regfile;
  localparam int N = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [4:0] addr;
  logic       wr_en, carry_we, carry_in, zero_we, zero_in;
  logic [7:0] wr_data, rd_data;
  logic       carry, zero;

  data_regfile #(.GPR_COUNT(N)) i_data_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .carry_we(carry_we), .carry_in(carry_in), .zero_we(zero_we), .zero_in(zero_in),
    .rd_data(rd_data), .carry(carry), .zero(zero)
  );

  logic [7:0] m [32];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic bit impl(int e);
    return e == 1 || e == 3 || e == 4 || (e >= 8 && e < 8 + N);
  endfunction

  function automatic int eff(logic [4:0] a);
    return (a == 5'd0) ? int'(m[4][4:0]) : int'(a);
  endfunction

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    int e = eff(a);
    return impl(e) ? m[e] : 8'h00;
  endfunction

  function automatic string tag(logic [4:0] a);
    int e = eff(a);
    if (a == 5'd0) return (e == 0) ? "R7" : "R6";
    if (e == 1) return "R4";
    if (e == 3) return "R8";
    if (e == 4) return "R5";
    if (impl(e)) return "R2";
    return "R3";
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(logic [4:0] a, logic we, logic [7:0] d,
                      logic cwe, logic ci, logic zwe, logic zi);
    int e;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    carry_we = cwe; carry_in = ci; zero_we = zwe; zero_in = zi;
    #1;
    chk(tag(a), rd_data, exp_rd(a));
    chk("R8", {6'd0, zero, carry}, {6'd0, m[3][2], m[3][0]});
    e = eff(a);
    @(posedge clk);
    if (we && impl(e)) m[e] = d;
    if (cwe) m[3][0] = ci;
    if (zwe) m[3][2] = zi;
  endtask

  task automatic look(logic [4:0] a, string r);
    @(negedge clk);
    addr = a; wr_en = 1'b0; carry_we = 1'b0; zero_we = 1'b0;
    #1;
    chk(r, rd_data, exp_rd(a));
    chk(r, {6'd0, zero, carry}, {6'd0, m[3][2], m[3][0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    rst_n = 1'b0; addr = '0; wr_en = 0; wr_data = '0;
    carry_we = 0; carry_in = 0; zero_we = 0; zero_in = 0;
    #2;
    chk("R1", rd_data, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 32; a++) begin
      look(5'(a), "R1");
      chk("R1", rd_data, 8'h00);
    end

    step(5'd8, 1, 8'h11, 0, 0, 0, 0);
    step(5'(8 + N - 1), 1, 8'h22, 0, 0, 0, 0);
    look(5'd8, "R2"); chk("R2", rd_data, 8'h11);
    look(5'(8 + N - 1), "R2"); chk("R2", rd_data, 8'h22);

    step(5'(8 + N), 1, 8'h33, 0, 0, 0, 0);
    step(5'd31, 1, 8'h44, 0, 0, 0, 0);
    step(5'd2, 1, 8'h45, 0, 0, 0, 0);
    step(5'd5, 1, 8'h46, 0, 0, 0, 0);
    step(5'd6, 1, 8'h47, 0, 0, 0, 0);
    step(5'd7, 1, 8'h48, 0, 0, 0, 0);
    look(5'(8 + N), "R3"); chk("R3", rd_data, 8'h00);
    look(5'd31, "R3"); chk("R3", rd_data, 8'h00);
    look(5'd2, "R3"); chk("R3", rd_data, 8'h00);
    look(5'd7, "R3"); chk("R3", rd_data, 8'h00);
    for (int a = 0; a < 32; a++) look(5'(a), "R3");

    step(5'd1, 1, 8'h5A, 0, 0, 0, 0);
    repeat (5) look(5'd3, "R4");
    look(5'd1, "R4"); chk("R4", rd_data, 8'h5A);

    step(5'd4, 1, 8'hE9, 0, 0, 0, 0);
    look(5'd4, "R5"); chk("R5", rd_data, 8'hE9);
    look(5'd0, "R6"); chk("R6", rd_data, 8'h00);
    step(5'd0, 1, 8'h77, 0, 0, 0, 0);
    look(5'd9, "R6"); chk("R6", rd_data, 8'h77);
    look(5'd0, "R11"); chk("R11", rd_data, 8'h77);
    look(5'd8, "R11"); chk("R11", rd_data, 8'h11);

    step(5'd4, 1, 8'h20, 0, 0, 0, 0);
    step(5'd0, 1, 8'h55, 0, 0, 0, 0);
    look(5'd0, "R7"); chk("R7", rd_data, 8'h00);
    for (int a = 1; a < 32; a++) look(5'(a), "R7");

    step(5'd3, 1, 8'hA5, 0, 0, 0, 0);
    look(5'd3, "R8"); chk("R8", rd_data, 8'hA5);
    chk("R8", {6'd0, zero, carry}, 8'h03);
    step(5'd8, 0, 8'h00, 1, 0, 0, 0);
    look(5'd3, "R9"); chk("R9", rd_data, 8'hA4);
    step(5'd8, 0, 8'h00, 0, 0, 1, 0);
    look(5'd3, "R9"); chk("R9", rd_data, 8'hA0);
    step(5'd3, 1, 8'hFF, 1, 0, 1, 0);
    look(5'd3, "R10"); chk("R10", rd_data, 8'hFA);
    step(5'd3, 1, 8'h00, 1, 1, 0, 0);
    look(5'd3, "R10"); chk("R10", rd_data, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      a = ($urandom % 8 == 0) ? 5'd4 : 5'($urandom % 32);
      if ($urandom % 6 == 0) a = 5'd0;
      step(a, 1'($urandom % 2), 8'($urandom), 1'($urandom % 3 == 0), 1'($urandom),
           1'($urandom % 3 == 0), 1'($urandom));
    end
    for (int a = 0; a < 32; a++) look(5'(a), "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule